// File: doc/BRIEF.md
# Paired-Page Variable-Size Translation Buffer

This block is a fully associative address translation buffer. It turns a 44-bit virtual address into a 40-bit physical address. All 64 entries are compared in parallel, and one lookup can be accepted on every clock with no stall. Each entry maps two neighbouring virtual pages, an even page and an odd page, onto two physical frames of its own. Each entry also carries its own page size, one of seven sizes from 4 KB to 16 MB that grow by a factor of four.

Software or a refill engine loads entries through an indexed write port. The translation result comes out one cycle after the request. It is one of three outcomes: a hit with its physical address, a no-match miss, or a miss because the selected half of the entry is invalid. A separate flag reports when more than one entry matched. Choosing which entry to replace and walking the page table are left to the logic around this block.

Top module: `tlb_pair_xlate`

## Requirements
- R1: After reset, no entry matches. A lookup reports a no-match miss, and all response outputs are low until a lookup is answered.
- R2: A request with `reqValid` high is answered by `rspValid` high exactly one cycle later. Requests on consecutive cycles each get their own response.
- R3: `wrMask` covers VA bits 24..13. Bit j of the mask stands for VA bit 13+j. The legal values are 0x000 (4 KB), 0x003 (16 KB), 0x00F (64 KB), 0x03F (256 KB), 0x0FF (1 MB), 0x3FF (4 MB) and 0xFFF (16 MB). An entry's tag holds VA bits 43..13. Tag bits under set mask bits are left out of the compare.
- R4: For a page size with k mask bit pairs set, VA bit 12+2k selects the frame. A 0 selects the even frame and a 1 selects the odd frame.
- R5: On a hit, PA[11:0] equals VA[11:0]. For each j below 12, PA[12+j] comes from VA[12+j] when mask bit j is set, and from frame bit j when it is clear. PA[39:24] always comes from the frame.
- R6: An entry matches only when its ASID equals `curAsid`, unless the entry's global bit is set.
- R7: When an entry matches but the valid bit of the selected half is clear, the block reports `rspInvalid`. `rspHit` stays low and `rspPa` is zero.
- R8: When no entry matches, the block reports `rspMiss` and `rspPa` is zero.
- R9: When two or more entries match, `rspMulti` is set and the lowest-indexed matching entry supplies the result.
- R10: A lookup issued in the same cycle as a write to the entry sees the entry's old contents. Lookups issued from the next cycle on see the new contents.
- R11: While `rspValid` is high, exactly one of `rspHit`, `rspMiss` and `rspInvalid` is high. While it is low, all the response flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Lookup request |
| reqVa | input | 44 | Virtual address to translate |
| curAsid | input | 8 | Current address space identifier |
| wrEn | input | 1 | Load entry strobe |
| wrIdx | input | 6 | Index of the entry to load |
| wrTag | input | 31 | VA bits 43..13 of the page pair |
| wrMask | input | 12 | Page size mask (R3) |
| wrAsid | input | 8 | Entry ASID |
| wrGlobal | input | 1 | Entry ignores the ASID |
| wrPfnEven | input | 28 | Even page frame number |
| wrValEven | input | 1 | Even page valid |
| wrPfnOdd | input | 28 | Odd page frame number |
| wrValOdd | input | 1 | Odd page valid |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No entry matched |
| rspInvalid | output | 1 | Matched, but the selected half is invalid |
| rspMulti | output | 1 | More than one entry matched |
| rspPa | output | 40 | Physical address, zero unless hit |

## Verification
An entry write and a lookup of that same entry can land in one cycle, and the answer then depends on the order between them. The bench drives a write that changes an entry's frame in the same cycle as a lookup of its page. It expects the old frame in that response. It then repeats the lookup in the very next cycle, with `reqValid` held high, and expects the new frame. Two matching entries are also loaded on purpose, to check the priority choice and the multiple-match flag in the same response.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  localparam int VA_W       = 44;
  localparam int PA_W       = 40;
  localparam int ASID_W     = 8;
  localparam int ENTRIES    = 64;
  localparam int PAGE_SHIFT = 12;
  localparam int SIZE_STEPS = 6;
  localparam int MASK_W     = 2 * SIZE_STEPS;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int TAG_W      = VA_W - PAGE_SHIFT - 1;
  localparam int PFN_W      = PA_W - PAGE_SHIFT;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             capture;
  } ctrl_strobe_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [MASK_W-1:0] mask;
    logic [ASID_W-1:0] asid;
    logic              glb;
    logic [PFN_W-1:0]  pfnEven;
    logic              valEven;
    logic [PFN_W-1:0]  pfnOdd;
    logic              valOdd;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_pair_ctrl.sv
module tlb_pair_ctrl
  import tlb_pair_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  output ctrl_strobe_t     strb,
  output logic             rspValid
);
  always_comb begin
    strb.load    = wrEn;
    strb.idx     = wrIdx;
    strb.capture = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/tlb_pair_dp.sv
module tlb_pair_dp
  import tlb_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  tlb_entry_t        wrEntry,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hitQ,
  output logic              missQ,
  output logic              invalidQ,
  output logic              multiQ,
  output logic [PA_W-1:0]   paQ
);
  logic [ENTRIES-1:0] match;
  logic [PFN_W-1:0]   pfnSel  [ENTRIES];
  logic               valSel  [ENTRIES];
  logic [MASK_W-1:0]  maskSel [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_entry_t        entR;
    logic              liveR;
    logic [TAG_W-1:0]  cmpMask;
    logic [MASK_W:0]   ext;
    logic [MASK_W:0]   pick;
    logic              odd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveR <= 1'b0;
        entR  <= '0;
      end else if (strb.load && strb.idx == IDX_W'(g)) begin
        liveR <= 1'b1;
        entR  <= wrEntry;
      end
    end

    assign cmpMask = ~{{(TAG_W-MASK_W){1'b0}}, entR.mask};
    assign ext     = {entR.mask, 1'b1};
    assign pick    = ext ^ (ext >> 1);
    assign odd     = |(va[PAGE_SHIFT+MASK_W:PAGE_SHIFT] & pick);
    assign match[g] = liveR
                    && (((va[VA_W-1:PAGE_SHIFT+1] ^ entR.tag) & cmpMask) == '0)
                    && (entR.glb || entR.asid == asid);
    assign pfnSel[g]  = odd ? entR.pfnOdd : entR.pfnEven;
    assign valSel[g]  = odd ? entR.valOdd : entR.valEven;
    assign maskSel[g] = entR.mask;
  end

  logic [IDX_W-1:0] win;
  logic             anyMatch, manyMatch;
  logic [PFN_W-1:0] winPfn;
  logic [PA_W-1:0]  paNext;

  always_comb begin
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) win = IDX_W'(i);
    end
  end

  assign anyMatch  = |match;
  assign manyMatch = |(match & (match - 1'b1));
  assign winPfn    = pfnSel[win];
  assign paNext    = {winPfn[PFN_W-1:MASK_W],
                      (winPfn[MASK_W-1:0] & ~maskSel[win]) |
                      (va[PAGE_SHIFT+MASK_W-1:PAGE_SHIFT] & maskSel[win]),
                      va[PAGE_SHIFT-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitQ <= 1'b0; missQ <= 1'b0; invalidQ <= 1'b0; multiQ <= 1'b0;
      paQ  <= '0;
    end else begin
      hitQ     <= strb.capture && anyMatch && valSel[win];
      missQ    <= strb.capture && !anyMatch;
      invalidQ <= strb.capture && anyMatch && !valSel[win];
      multiQ   <= strb.capture && manyMatch;
      paQ      <= (strb.capture && anyMatch && valSel[win]) ? paNext : '0;
    end
  end
endmodule

// File: rtl/tlb_pair_xlate.sv
module tlb_pair_xlate
  import tlb_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [MASK_W-1:0] wrMask,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrGlobal,
  input  logic [PFN_W-1:0]  wrPfnEven,
  input  logic              wrValEven,
  input  logic [PFN_W-1:0]  wrPfnOdd,
  input  logic              wrValOdd,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspInvalid,
  output logic              rspMulti,
  output logic [PA_W-1:0]   rspPa
);
  ctrl_strobe_t strb;
  tlb_entry_t   wrEntry;

  assign wrEntry = '{tag: wrTag, mask: wrMask, asid: wrAsid, glb: wrGlobal,
                     pfnEven: wrPfnEven, valEven: wrValEven,
                     pfnOdd: wrPfnOdd, valOdd: wrValOdd};

  tlb_pair_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrEn(wrEn), .wrIdx(wrIdx),
    .strb(strb), .rspValid(rspValid)
  );

  tlb_pair_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEntry(wrEntry), .va(reqVa),
    .asid(curAsid), .hitQ(rspHit), .missQ(rspMiss), .invalidQ(rspInvalid),
    .multiQ(rspMulti), .paQ(rspPa)
  );
endmodule

// File: rtl/tlb_pair_xlate_chk.sv
module tlb_pair_xlate_chk
  import tlb_pair_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVa,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspMiss,
  input logic            rspInvalid,
  input logic            rspMulti,
  input logic [PA_W-1:0] rspPa
);
  assert_req_answered_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_req_no_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $onehot({rspHit, rspMiss, rspInvalid}));
  assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMiss || rspInvalid || rspMulti));
  assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (!rspHit || rspPa[PAGE_SHIFT-1:0] == $past(reqVa[PAGE_SHIFT-1:0])));
  assert_pa_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rspHit |-> rspPa == '0);
  assert_multi_has_match_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspMulti |-> !rspMiss);
endmodule

bind tlb_pair_xlate tlb_pair_xlate_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
  .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss),
  .rspInvalid(rspInvalid), .rspMulti(rspMulti), .rspPa(rspPa)
);

// File: tb/sim_tlb_pair_xlate.sv
module sim_tlb_pair_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [43:0] reqVa = '0;
  logic [7:0]  curAsid = '0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [30:0] wrTag = '0;
  logic [11:0] wrMask = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrGlobal = 1'b0;
  logic [27:0] wrPfnEven = '0;
  logic        wrValEven = 1'b0;
  logic [27:0] wrPfnOdd = '0;
  logic        wrValOdd = 1'b0;
  logic        rspValid, rspHit, rspMiss, rspInvalid, rspMulti;
  logic [39:0] rspPa;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlb_pair_xlate u0 (.*);

  function automatic logic [39:0] mkPa(logic [27:0] pfn, int k, logic [43:0] va);
    logic [39:0] pa = {pfn, 12'h000};
    for (int b = 0; b < 12 + 2 * k; b++) pa[b] = va[b];
    return pa;
  endfunction

  task automatic note(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkRsp(bit eH, bit eM, bit eI, bit eMu, logic [39:0] ePa, string req);
    note(rspValid === 1'b1, req, "rspValid", 64'(rspValid), 64'd1);
    note({rspHit, rspMiss, rspInvalid, rspMulti} === {eH, eM, eI, eMu}, req, "flags hit/miss/inv/multi",
         64'({rspHit, rspMiss, rspInvalid, rspMulti}), 64'({eH, eM, eI, eMu}));
    note(rspPa === ePa, req, "rspPa", 64'(rspPa), 64'(ePa));
    note($countones({rspHit, rspMiss, rspInvalid}) == 1, "R11", "single outcome",
         64'({rspHit, rspMiss, rspInvalid}), 64'd0);
  endtask

  task automatic putEntry(int idx, logic [30:0] tag, logic [11:0] mask, logic [7:0] asid,
                          bit glb, logic [27:0] pe, bit ve, logic [27:0] po, bit vo);
    wrIdx = 6'(idx); wrTag = tag; wrMask = mask; wrAsid = asid; wrGlobal = glb;
    wrPfnEven = pe; wrValEven = ve; wrPfnOdd = po; wrValOdd = vo; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic look(logic [43:0] va, logic [7:0] asid, bit eH, bit eM, bit eI, bit eMu,
                      logic [39:0] ePa, string req);
    reqVa = va; curAsid = asid; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(eH, eM, eI, eMu, ePa, req);
  endtask

  task automatic testReset();
    note({rspValid, rspHit, rspMiss, rspInvalid, rspMulti} == 5'b0, "R1", "idle outputs after reset",
         64'({rspValid, rspHit, rspMiss, rspInvalid, rspMulti}), 64'd0);
    look(44'h0, 8'h0, 0, 1, 0, 0, 40'h0, "R1");
    look(44'h0_0123_4567, 8'h3, 0, 1, 0, 0, 40'h0, "R8");
  endtask

  task automatic testSmallPage();
    putEntry(5, 31'h0012_3456, 12'h000, 8'h3, 0, 28'h00AAAAA, 1, 28'h00BBBBB, 1);
    look({31'h0012_3456, 1'b0, 12'h345}, 8'h3, 1, 0, 0, 0, {28'h00AAAAA, 12'h345}, "R4");
    look({31'h0012_3456, 1'b1, 12'h345}, 8'h3, 1, 0, 0, 0, {28'h00BBBBB, 12'h345}, "R4");
    look({31'h0012_3457, 1'b0, 12'h345}, 8'h3, 0, 1, 0, 0, 40'h0, "R3");
  endtask

  task automatic testLargePage();
    logic [43:0] va;
    putEntry(10, {19'h51234, 12'h000}, 12'hFFF, 8'h3, 0, 28'h0FEDCBA, 1, 28'h0123456, 1);
    va = {19'h51234, 1'b0, 24'hABCDEF};
    look(va, 8'h3, 1, 0, 0, 0, mkPa(28'h0FEDCBA, 6, va), "R5");
    va = {19'h51234, 1'b1, 24'h13579B};
    look(va, 8'h3, 1, 0, 0, 0, mkPa(28'h0123456, 6, va), "R3");
  endtask

  task automatic testMidPage();
    logic [43:0] va;
    putEntry(40, 31'h2468_ACE0, 12'h00F, 8'h3, 0, 28'h0C0FFEE, 1, 28'h0BEEF00, 1);
    va = {27'h2468ACE, 1'b1, 16'hE5A7};
    look(va, 8'h3, 1, 0, 0, 0, mkPa(28'h0BEEF00, 2, va), "R4");
    va = {27'h2468ACE, 1'b0, 16'h1FFF};
    look(va, 8'h3, 1, 0, 0, 0, mkPa(28'h0C0FFEE, 2, va), "R5");
  endtask

  task automatic testAsid();
    look({31'h0012_3456, 1'b0, 12'h345}, 8'h4, 0, 1, 0, 0, 40'h0, "R6");
    putEntry(50, 31'h0000_0777, 12'h000, 8'h9, 1, 28'h0000777, 1, 28'h0000778, 1);
    look({31'h0000_0777, 1'b1, 12'h010}, 8'h4, 1, 0, 0, 0, {28'h0000778, 12'h010}, "R6");
  endtask

  task automatic testInvalid();
    putEntry(51, 31'h0000_0888, 12'h000, 8'h3, 0, 28'h0000881, 1, 28'h0000882, 0);
    look({31'h0000_0888, 1'b1, 12'h020}, 8'h3, 0, 0, 1, 0, 40'h0, "R7");
    look({31'h0000_0888, 1'b0, 12'h020}, 8'h3, 1, 0, 0, 0, {28'h0000881, 12'h020}, "R7");
  endtask

  task automatic testMulti();
    putEntry(20, 31'h0000_0999, 12'h000, 8'h3, 0, 28'h0001111, 1, 28'h0001111, 1);
    putEntry(7,  31'h0000_0999, 12'h000, 8'h3, 0, 28'h0002222, 1, 28'h0002222, 1);
    look({31'h0000_0999, 1'b0, 12'h0F0}, 8'h3, 1, 0, 0, 1, {28'h0002222, 12'h0F0}, "R9");
  endtask

  task automatic testSameCycle();
    putEntry(30, 31'h0000_0AAA, 12'h000, 8'h3, 0, 28'h0003333, 1, 28'h0003333, 1);
    reqVa = {31'h0000_0AAA, 1'b0, 12'h777}; curAsid = 8'h3; reqValid = 1'b1;
    wrIdx = 6'd30; wrPfnEven = 28'h0004444; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    checkRsp(1, 0, 0, 0, {28'h0003333, 12'h777}, "R10");
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(1, 0, 0, 0, {28'h0004444, 12'h777}, "R10");
    @(negedge clk);
    note(rspValid === 1'b0 && rspHit === 1'b0, "R2", "no request no response",
         64'({rspValid, rspHit}), 64'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSmallPage();
    testLargePage();
    testMidPage();
    testAsid();
    testInvalid();
    testMulti();
    testSameCycle();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not end");
    finish();
  end
endmodule